// File: doc/BRIEF.md
# SMBus Master Transaction Sequencer

This block runs complete SMBus master transactions from a script that the host leaves in a transmit FIFO. The host pushes tagged entries: a target address, an optional command code, a byte count or data bytes, and a read address. It then selects one of ten protocol codes and pulses `go`. The sequencer works through the entries in an order set by the protocol. It drives a byte-level bus engine with start, write, read-with-ACK, read-with-NACK and stop operations, and it pushes every byte it receives into a receive FIFO.

Each transmit entry is 9 bits wide. Bit 8 is an end-of-write marker and bits 7:0 are the byte to send. For every read protocol except the process call, the repeated start falls before the third entry. For the process call, it falls before the entry that carries the marker. Completion is shown by a busy flag that clears itself, a result code, and a sticky completion event that the host clears by writing 1. A soft reset, two FIFO flush strobes and a speed-mode bit passed to the engine complete the control set.

Top module: `smb_seq`

## Requirements
- R1: When `go` is pulsed while `enable` is high, no transaction is running and `proto` is at most 9, `busy` rises on the next cycle and the first engine operation is a start. The transaction always ends with a stop, after which `busy` clears and `evt_done` sets. A transaction that completes normally reports `status` 0.
- R2: A quick command (proto 0) consumes only the address entry, writes it, then stops. If the first written entry is NACKed, in any protocol, `status` is 1 (address NACK).
- R3: Send byte (1), write byte (3), write word (5) and block write (7) write transmit entries in order until an entry with bit 8 set has been written, then stop, with a single start.
- R4: Read byte (4) and read word (6) write the address and the command, issue a repeated start, and write the third entry. They then read `rdlen` bytes (a value of 0 counts as 1), ACK every byte but the last, NACK the last, and push each byte into the receive FIFO.
- R5: Receive byte (2) writes the address entry with bit 0 forced to 1, then reads one byte with NACK.
- R6: Block read (8) and the block process call (9) read a count byte with ACK and push it first. They then read min(count, BLK_MAX) data bytes, NACKing the last one; a count of 0 stops at once. The process call writes entries until the marked entry, and that entry is preceded by a repeated start.
- R7: A NACK on any write after the first gives `status` 2 and goes straight to a stop.
- R8: If the transmit FIFO is empty when another entry is needed, the transaction ends with `status` 3 and a stop.
- R9: A launch with `proto` above 9 gives `status` 4 and sets `evt_done`. It leaves `busy` low and produces no engine request.
- R10: Writing 1 to `evt_clr` clears `evt_done`; while `evt_clr` is 0, `evt_done` holds.
- R11: `soft_rst` aborts any transaction: `busy`, `eng_req` and `status` return to 0 and both FIFOs are emptied. While `enable` is low, `go` is ignored.
- R12: `tx_flush` empties the transmit FIFO and `rx_flush` empties the receive FIFO.
- R13: `eng_fast` follows `cfg_fast` one cycle later (1 selects 400 kHz timing, 0 selects 100 kHz).
- R14: An engine request holds `eng_req`, `eng_op` and `eng_wdata` stable until `eng_done`. Operation codes are 1 start, 2 write, 3 read with ACK, 4 read with NACK, and 5 stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Soft reset of the sequencer and both FIFOs |
| enable | input | 1 | Block enable; `go` is ignored when low |
| cfg_fast | input | 1 | Speed-mode bit (1 = 400 kHz) |
| tx_push | input | 1 | Push `tx_entry` into the transmit FIFO |
| tx_entry | input | 9 | Transmit entry: bit 8 end-of-write marker, bits 7:0 byte |
| tx_flush | input | 1 | Empty the transmit FIFO |
| tx_full | output | 1 | Transmit FIFO full |
| rx_pop | input | 1 | Pop the receive FIFO; byte valid on the next cycle |
| rx_byte | output | 8 | Last popped receive byte |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_flush | input | 1 | Empty the receive FIFO |
| go | input | 1 | Launch a transaction |
| proto | input | 4 | Protocol code, 0 to 9 |
| rdlen | input | LEN_W | Read length for read byte and read word |
| busy | output | 1 | Transaction running; clears itself |
| status | output | 3 | Result: 0 ok, 1 address NACK, 2 data NACK, 3 underrun, 4 bad protocol |
| evt_done | output | 1 | Sticky completion event |
| evt_clr | input | 1 | Write-1-to-clear for `evt_done` |
| eng_req | output | 1 | Request to the byte engine |
| eng_op | output | 3 | Engine operation code |
| eng_wdata | output | 8 | Byte to write |
| eng_done | input | 1 | Engine finished the current operation |
| eng_nack | input | 1 | The written byte was NACKed |
| eng_rdata | input | 8 | Byte read by the engine |
| eng_fast | output | 1 | Speed mode passed to the engine |

## Verification
The bench builds the block with TX_DEPTH 8, RX_DEPTH 16 and BLK_MAX 8. The small block limit lets a returned count of 12 reach the clamp in a few dozen cycles, so the short path where only eight data bytes follow the count byte is checked. A count of 0 is also checked. A transmit depth of 8 still holds the longest script, a five-entry process call. The receive depth of 16 holds the clamped block read of nine bytes without overflowing.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_START   = 3'd1,
    OP_WRITE   = 3'd2,
    OP_RD_ACK  = 3'd3,
    OP_RD_NACK = 3'd4,
    OP_STOP    = 3'd5
  } eng_op_e;

  localparam logic [3:0] PR_QUICK = 4'd0;
  localparam logic [3:0] PR_SEND  = 4'd1;
  localparam logic [3:0] PR_RECV  = 4'd2;
  localparam logic [3:0] PR_WBYTE = 4'd3;
  localparam logic [3:0] PR_RBYTE = 4'd4;
  localparam logic [3:0] PR_WWORD = 4'd5;
  localparam logic [3:0] PR_RWORD = 4'd6;
  localparam logic [3:0] PR_BWR   = 4'd7;
  localparam logic [3:0] PR_BRD   = 4'd8;
  localparam logic [3:0] PR_PCALL = 4'd9;

  localparam logic [2:0] ST_OK        = 3'd0;
  localparam logic [2:0] ST_ADDR_NACK = 3'd1;
  localparam logic [2:0] ST_DATA_NACK = 3'd2;
  localparam logic [2:0] ST_UNDERRUN  = 3'd3;
  localparam logic [2:0] ST_BAD_PROTO = 3'd4;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_FETCH, S_LOAD, S_RSTART, S_WRITE, S_READ, S_STOP
  } seq_state_e;

endpackage

// File: rtl/smb_seq_fifo.sv
module smb_seq_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wp;
  logic [AW:0]      rp;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);

  // storage and registered read port kept free of reset for RAM inference
  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[AW-1:0]] <= wdata;
    if (pop && !empty) rdata <= mem[rp[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/smb_seq_ctl.sv
module smb_seq_ctl (
  input  logic clk,
  input  logic rst,
  input  logic rst_all,
  input  logic cfg_fast,
  input  logic done_set,
  input  logic evt_clr,
  output logic evt_done,
  output logic eng_fast
);
  always_ff @(posedge clk) begin
    if (rst) eng_fast <= 1'b0;
    else     eng_fast <= cfg_fast;
  end

  always_ff @(posedge clk) begin
    if (rst_all)       evt_done <= 1'b0;
    else if (done_set) evt_done <= 1'b1;
    else if (evt_clr)  evt_done <= 1'b0;
  end
endmodule

// File: rtl/smb_seq_fsm.sv
module smb_seq_fsm
  import smb_seq_pkg::*;
#(
  parameter int BLK_MAX = 32,
  parameter int LEN_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             enable,
  input  logic [3:0]       proto,
  input  logic [LEN_W-1:0] rdlen,
  input  logic             tx_empty,
  output logic             tx_pop,
  input  logic [8:0]       tx_entry,
  input  logic             rx_full,
  output logic             rx_push,
  output logic [7:0]       rx_data,
  output logic             eng_req,
  output logic [2:0]       eng_op,
  output logic [7:0]       eng_wdata,
  input  logic             eng_done,
  input  logic             eng_nack,
  input  logic [7:0]       eng_rdata,
  output logic             busy,
  output logic [2:0]       status,
  output logic             done_set
);
  localparam int CW    = $clog2(BLK_MAX + 1);
  localparam int REM_W = (LEN_W > CW) ? LEN_W : CW;

  seq_state_e       state;
  logic [3:0]       proto_q;
  logic [LEN_W-1:0] len_q;
  logic [1:0]       widx;     // written entries, saturating at 3
  logic [REM_W-1:0] rem;
  logic             cnt_ph;
  logic             rs_done;

  logic             rd_proto;
  logic             need_rs;
  logic [7:0]       wbyte;
  logic [7:0]       blk_n;
  logic             bad_go;

  always_comb begin
    rd_proto = (proto_q == PR_RBYTE) || (proto_q == PR_RWORD) ||
               (proto_q == PR_BRD)   || (proto_q == PR_PCALL);
    need_rs  = rd_proto && !rs_done &&
               ((proto_q == PR_PCALL) ? tx_entry[8] : (widx == 2'd2));
    wbyte    = tx_entry[7:0] | {7'd0, (proto_q == PR_RECV)};
    blk_n    = (eng_rdata > 8'(BLK_MAX)) ? 8'(BLK_MAX) : eng_rdata;
    bad_go   = (state == S_IDLE) && go && enable && (proto > PR_PCALL);
    done_set = bad_go || ((state == S_STOP) && eng_done);
    tx_pop   = (state == S_FETCH) && !tx_empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      busy      <= 1'b0;
      status    <= ST_OK;
      eng_req   <= 1'b0;
      eng_op    <= OP_NONE;
      eng_wdata <= '0;
      rx_push   <= 1'b0;
      rx_data   <= '0;
      proto_q   <= '0;
      len_q     <= '0;
      widx      <= '0;
      rem       <= '0;
      cnt_ph    <= 1'b0;
      rs_done   <= 1'b0;
    end else begin
      rx_push <= 1'b0;
      case (state)
        S_IDLE: begin
          if (bad_go) begin
            status <= ST_BAD_PROTO;
          end else if (go && enable) begin
            busy    <= 1'b1;
            status  <= ST_OK;
            proto_q <= proto;
            len_q   <= (rdlen == '0) ? LEN_W'(1) : rdlen;
            widx    <= '0;
            rs_done <= 1'b0;
            cnt_ph  <= 1'b0;
            eng_req <= 1'b1;
            eng_op  <= OP_START;
            state   <= S_START;
          end
        end
        S_START: begin
          if (eng_done) begin
            eng_req <= 1'b0;
            state   <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (tx_empty) begin
            status  <= ST_UNDERRUN;
            eng_req <= 1'b1;
            eng_op  <= OP_STOP;
            state   <= S_STOP;
          end else begin
            state <= S_LOAD;
          end
        end
        S_LOAD: begin
          eng_req <= 1'b1;
          if (need_rs) begin
            rs_done <= 1'b1;
            eng_op  <= OP_START;
            state   <= S_RSTART;
          end else begin
            eng_op    <= OP_WRITE;
            eng_wdata <= wbyte;
            state     <= S_WRITE;
          end
        end
        S_RSTART: begin
          if (eng_done) begin
            eng_op    <= OP_WRITE;
            eng_wdata <= wbyte;
            state     <= S_WRITE;
          end
        end
        S_WRITE: begin
          if (eng_done) begin
            if (eng_nack) begin
              status <= (widx == 2'd0) ? ST_ADDR_NACK : ST_DATA_NACK;
              eng_op <= OP_STOP;
              state  <= S_STOP;
            end else begin
              if (widx != 2'd3) widx <= widx + 2'd1;
              case (proto_q)
                PR_QUICK: begin
                  eng_op <= OP_STOP;
                  state  <= S_STOP;
                end
                PR_RECV: begin
                  rem    <= REM_W'(1);
                  eng_op <= OP_RD_NACK;
                  state  <= S_READ;
                end
                PR_RBYTE, PR_RWORD: begin
                  if (widx == 2'd2) begin
                    rem    <= REM_W'(len_q);
                    eng_op <= (len_q == LEN_W'(1)) ? OP_RD_NACK : OP_RD_ACK;
                    state  <= S_READ;
                  end else begin
                    eng_req <= 1'b0;
                    state   <= S_FETCH;
                  end
                end
                PR_BRD, PR_PCALL: begin
                  if ((proto_q == PR_BRD) ? (widx == 2'd2) : tx_entry[8]) begin
                    cnt_ph <= 1'b1;
                    eng_op <= OP_RD_ACK;
                    state  <= S_READ;
                  end else begin
                    eng_req <= 1'b0;
                    state   <= S_FETCH;
                  end
                end
                default: begin
                  if (tx_entry[8]) begin
                    eng_op <= OP_STOP;
                    state  <= S_STOP;
                  end else begin
                    eng_req <= 1'b0;
                    state   <= S_FETCH;
                  end
                end
              endcase
            end
          end
        end
        S_READ: begin
          if (eng_done) begin
            rx_push <= !rx_full;
            rx_data <= eng_rdata;
            if (cnt_ph) begin
              cnt_ph <= 1'b0;
              if (blk_n == 8'd0) begin
                eng_op <= OP_STOP;
                state  <= S_STOP;
              end else begin
                rem    <= REM_W'(blk_n);
                eng_op <= (blk_n == 8'd1) ? OP_RD_NACK : OP_RD_ACK;
              end
            end else if (rem <= REM_W'(1)) begin
              eng_op <= OP_STOP;
              state  <= S_STOP;
            end else begin
              rem    <= rem - REM_W'(1);
              eng_op <= (rem == REM_W'(2)) ? OP_RD_NACK : OP_RD_ACK;
            end
          end
        end
        S_STOP: begin
          if (eng_done) begin
            eng_req <= 1'b0;
            busy    <= 1'b0;
            state   <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smb_seq.sv
module smb_seq #(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 64,
  parameter int BLK_MAX  = 32,
  parameter int LEN_W    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             enable,
  input  logic             cfg_fast,
  input  logic             tx_push,
  input  logic [8:0]       tx_entry,
  input  logic             tx_flush,
  output logic             tx_full,
  input  logic             rx_pop,
  output logic [7:0]       rx_byte,
  output logic             rx_empty,
  input  logic             rx_flush,
  input  logic             go,
  input  logic [3:0]       proto,
  input  logic [LEN_W-1:0] rdlen,
  output logic             busy,
  output logic [2:0]       status,
  output logic             evt_done,
  input  logic             evt_clr,
  output logic             eng_req,
  output logic [2:0]       eng_op,
  output logic [7:0]       eng_wdata,
  input  logic             eng_done,
  input  logic             eng_nack,
  input  logic [7:0]       eng_rdata,
  output logic             eng_fast
);
  logic       rst_all;
  logic       tx_empty;
  logic       tx_pop;
  logic [8:0] tx_head;
  logic       rx_full;
  logic       rx_push;
  logic [7:0] rx_data;
  logic       done_set;

  assign rst_all = rst | soft_rst;

  smb_seq_fifo #(.WIDTH(9), .DEPTH(TX_DEPTH)) tx_fifo_i (
    .clk(clk), .clr(rst_all | tx_flush),
    .push(tx_push), .wdata(tx_entry),
    .pop(tx_pop), .rdata(tx_head),
    .empty(tx_empty), .full(tx_full)
  );

  smb_seq_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) rx_fifo_i (
    .clk(clk), .clr(rst_all | rx_flush),
    .push(rx_push), .wdata(rx_data),
    .pop(rx_pop), .rdata(rx_byte),
    .empty(rx_empty), .full(rx_full)
  );

  smb_seq_fsm #(.BLK_MAX(BLK_MAX), .LEN_W(LEN_W)) fsm_i (
    .clk(clk), .rst(rst_all),
    .go(go), .enable(enable), .proto(proto), .rdlen(rdlen),
    .tx_empty(tx_empty), .tx_pop(tx_pop), .tx_entry(tx_head),
    .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data),
    .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
    .eng_done(eng_done), .eng_nack(eng_nack), .eng_rdata(eng_rdata),
    .busy(busy), .status(status), .done_set(done_set)
  );

  smb_seq_ctl ctl_i (
    .clk(clk), .rst(rst), .rst_all(rst_all),
    .cfg_fast(cfg_fast), .done_set(done_set), .evt_clr(evt_clr),
    .evt_done(evt_done), .eng_fast(eng_fast)
  );
endmodule

// File: rtl/smb_seq_chk.sv
module smb_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       soft_rst,
  input logic       go,
  input logic       enable,
  input logic [3:0] proto,
  input logic       cfg_fast,
  input logic       evt_clr,
  input logic       busy,
  input logic [2:0] status,
  input logic       evt_done,
  input logic       eng_req,
  input logic [2:0] eng_op,
  input logic [7:0] eng_wdata,
  input logic       eng_done,
  input logic       eng_fast
);
  assert_req_hold_R14: assert property (@(posedge clk) disable iff (rst || soft_rst)
    eng_req && !eng_done |=> eng_req && $stable(eng_op) && $stable(eng_wdata));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !eng_req);

  assert_bad_proto_R9: assert property (@(posedge clk) disable iff (rst || soft_rst)
    go && enable && !busy && (proto > 4'd9) |=> !busy && (status == 3'd4) && evt_done);

  assert_launch_start_R1: assert property (@(posedge clk) disable iff (rst || soft_rst)
    $rose(busy) |-> eng_req && (eng_op == 3'd1));

  assert_end_stop_R1: assert property (@(posedge clk) disable iff (rst || soft_rst)
    $fell(busy) && !$past(soft_rst) |-> ($past(eng_op) == 3'd5) && $past(eng_done));

  assert_evt_clear_R10: assert property (@(posedge clk) disable iff (rst || soft_rst)
    evt_clr && !busy && !go |=> !evt_done);

  assert_speed_R13: assert property (@(posedge clk) disable iff (rst)
    cfg_fast |=> eng_fast);
endmodule

bind smb_seq smb_seq_chk chk_i (.*);

// File: tb/smb_seq_tb_top.sv
module smb_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TXD = 8;
  localparam int RXD = 16;
  localparam int BLKM = 8;
  localparam int LW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1, soft_rst = 1'b0, enable = 1'b1, cfg_fast = 1'b0;
  logic tx_push = 1'b0, tx_flush = 1'b0, rx_pop = 1'b0, rx_flush = 1'b0;
  logic [8:0] tx_entry = '0;
  logic go = 1'b0, evt_clr = 1'b0;
  logic [3:0] proto = '0;
  logic [LW-1:0] rdlen = '0;
  logic eng_done = 1'b0, eng_nack = 1'b0;
  logic [7:0] eng_rdata = '0;
  logic tx_full, rx_empty, busy, evt_done, eng_req, eng_fast;
  logic [7:0] rx_byte, eng_wdata;
  logic [2:0] status, eng_op;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_seq #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .BLK_MAX(BLKM), .LEN_W(LW)) dut_i (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .enable(enable), .cfg_fast(cfg_fast),
    .tx_push(tx_push), .tx_entry(tx_entry), .tx_flush(tx_flush), .tx_full(tx_full),
    .rx_pop(rx_pop), .rx_byte(rx_byte), .rx_empty(rx_empty), .rx_flush(rx_flush),
    .go(go), .proto(proto), .rdlen(rdlen), .busy(busy), .status(status),
    .evt_done(evt_done), .evt_clr(evt_clr), .eng_req(eng_req), .eng_op(eng_op),
    .eng_wdata(eng_wdata), .eng_done(eng_done), .eng_nack(eng_nack),
    .eng_rdata(eng_rdata), .eng_fast(eng_fast)
  );

  int n_checks = 0, n_fail = 0;
  // engine model state
  int n_start, n_write, n_rack, n_rnack, n_stop, rd_idx, wr_idx, nack_at;
  logic [7:0] first_wr, blk_cnt;
  logic blk_mode;

  typedef struct packed {
    logic [3:0] pr; logic [2:0] ntx; logic [0:5][8:0] tx; logic [5:0] len;
    logic [3:0] nk; logic [7:0] cnt; logic [2:0] st; logic [1:0] starts;
    logic [3:0] wr; logic [4:0] rack; logic [1:0] rnack; logic [4:0] rxn; logic [7:0] first;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'd0,3'd1,{9'h0A0,9'h0,9'h0,9'h0,9'h0,9'h0},6'd0,4'hF,8'd0,3'd0,2'd1,4'd1,5'd0,2'd0,5'd0,8'hA0},
    '{4'd0,3'd1,{9'h0A0,9'h0,9'h0,9'h0,9'h0,9'h0},6'd0,4'h0,8'd0,3'd1,2'd1,4'd1,5'd0,2'd0,5'd0,8'hA0},
    '{4'd1,3'd2,{9'h0A0,9'h155,9'h0,9'h0,9'h0,9'h0},6'd0,4'hF,8'd0,3'd0,2'd1,4'd2,5'd0,2'd0,5'd0,8'hA0},
    '{4'd3,3'd3,{9'h0A0,9'h010,9'h177,9'h0,9'h0,9'h0},6'd0,4'hF,8'd0,3'd0,2'd1,4'd3,5'd0,2'd0,5'd0,8'hA0},
    '{4'd5,3'd4,{9'h0A0,9'h010,9'h011,9'h122,9'h0,9'h0},6'd0,4'hF,8'd0,3'd0,2'd1,4'd4,5'd0,2'd0,5'd0,8'hA0},
    '{4'd7,3'd5,{9'h0A0,9'h010,9'h002,9'h033,9'h144,9'h0},6'd0,4'hF,8'd0,3'd0,2'd1,4'd5,5'd0,2'd0,5'd0,8'hA0},
    '{4'd4,3'd3,{9'h0A0,9'h010,9'h0A1,9'h0,9'h0,9'h0},6'd1,4'hF,8'd0,3'd0,2'd2,4'd3,5'd0,2'd1,5'd1,8'hA0},
    '{4'd6,3'd3,{9'h0A0,9'h010,9'h0A1,9'h0,9'h0,9'h0},6'd2,4'hF,8'd0,3'd0,2'd2,4'd3,5'd1,2'd1,5'd2,8'hA0},
    '{4'd4,3'd3,{9'h0A0,9'h010,9'h0A1,9'h0,9'h0,9'h0},6'd0,4'hF,8'd0,3'd0,2'd2,4'd3,5'd0,2'd1,5'd1,8'hA0},
    '{4'd2,3'd1,{9'h0A0,9'h0,9'h0,9'h0,9'h0,9'h0},6'd0,4'hF,8'd0,3'd0,2'd1,4'd1,5'd0,2'd1,5'd1,8'hA1},
    '{4'd8,3'd3,{9'h0A0,9'h010,9'h0A1,9'h0,9'h0,9'h0},6'd0,4'hF,8'd3,3'd0,2'd2,4'd3,5'd3,2'd1,5'd4,8'hA0},
    '{4'd8,3'd3,{9'h0A0,9'h010,9'h0A1,9'h0,9'h0,9'h0},6'd0,4'hF,8'd12,3'd0,2'd2,4'd3,5'd8,2'd1,5'd9,8'hA0},
    '{4'd8,3'd3,{9'h0A0,9'h010,9'h0A1,9'h0,9'h0,9'h0},6'd0,4'hF,8'd0,3'd0,2'd2,4'd3,5'd1,2'd0,5'd1,8'hA0},
    '{4'd9,3'd5,{9'h0A0,9'h010,9'h001,9'h055,9'h1A1,9'h0},6'd0,4'hF,8'd2,3'd0,2'd2,4'd5,5'd2,2'd1,5'd3,8'hA0},
    '{4'd3,3'd3,{9'h0A0,9'h010,9'h177,9'h0,9'h0,9'h0},6'd0,4'h1,8'd0,3'd2,2'd1,4'd2,5'd0,2'd0,5'd0,8'hA0},
    '{4'd3,3'd2,{9'h0A0,9'h010,9'h0,9'h0,9'h0,9'h0},6'd0,4'hF,8'd0,3'd3,2'd1,4'd2,5'd0,2'd0,5'd0,8'hA0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic model_clear();
    n_start = 0; n_write = 0; n_rack = 0; n_rnack = 0; n_stop = 0;
    rd_idx = 0; wr_idx = 0; first_wr = 8'h00;
  endtask

  // byte engine model: answers each request two cycles after accepting it
  initial begin
    int lat;
    logic pend;
    logic [2:0] op_l;
    logic [7:0] wd_l;
    pend = 1'b0; lat = 0; op_l = '0; wd_l = '0;
    model_clear(); nack_at = 15; blk_cnt = 0; blk_mode = 0;
    forever begin
      @(negedge clk);
      if (eng_done) begin
        eng_done = 1'b0; eng_nack = 1'b0;
      end else if (pend && !eng_req) begin
        pend = 1'b0;
      end else if (eng_req && !pend) begin
        pend = 1'b1; lat = 2; op_l = eng_op; wd_l = eng_wdata;
      end else if (pend) begin
        lat--;
        if (lat == 0) begin
          pend = 1'b0;
          case (op_l)
            3'd1: n_start++;
            3'd2: begin
              if (wr_idx == 0) first_wr = wd_l;
              eng_nack = (wr_idx == nack_at);
              wr_idx++; n_write++;
            end
            3'd3, 3'd4: begin
              eng_rdata = (blk_mode && rd_idx == 0) ? blk_cnt : 8'(8'h80 + rd_idx);
              rd_idx++;
              if (op_l == 3'd3) n_rack++; else n_rnack++;
            end
            3'd5: n_stop++;
            default: ;
          endcase
          eng_done = 1'b1;
        end
      end
    end
  end

  task automatic push_entry(input logic [8:0] e);
    tick(); tx_push = 1'b1; tx_entry = e;
    tick(); tx_push = 1'b0;
  endtask

  task automatic pulse_flush_tx();
    tick(); tx_flush = 1'b1; tick(); tx_flush = 1'b0;
  endtask

  task automatic launch(input logic [3:0] p, input logic [LW-1:0] l);
    tick(); go = 1'b1; proto = p; rdlen = l;
    tick(); go = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 3000; k++) begin
      if (!busy) break;
      tick();
    end
  endtask

  task automatic clear_evt();
    tick(); evt_clr = 1'b1; tick(); evt_clr = 1'b0;
  endtask

  task automatic run_vec(input int i);
    vec_t v;
    int got;
    v = VECS[i];
    pulse_flush_tx();
    model_clear();
    nack_at = int'(v.nk); blk_cnt = v.cnt; blk_mode = (v.pr == 4'd8) || (v.pr == 4'd9);
    for (int e = 0; e < int'(v.ntx); e++) push_entry(v.tx[e]);
    launch(v.pr, v.len);
    wait_idle();
    chk($sformatf("R1 vec%0d busy", i), 32'(busy), 0);
    chk($sformatf("R1 vec%0d evt", i), 32'(evt_done), 1);
    chk($sformatf("R7 R8 vec%0d status", i), 32'(status), 32'(v.st));
    chk($sformatf("R4 R6 vec%0d starts", i), 32'(n_start), 32'(v.starts));
    chk($sformatf("R3 vec%0d writes", i), 32'(n_write), 32'(v.wr));
    chk($sformatf("R4 vec%0d ack reads", i), 32'(n_rack), 32'(v.rack));
    chk($sformatf("R4 vec%0d nack reads", i), 32'(n_rnack), 32'(v.rnack));
    chk($sformatf("R1 vec%0d stops", i), 32'(n_stop), 1);
    chk($sformatf("R2 R5 vec%0d first byte", i), 32'(first_wr), 32'(v.first));
    got = 0;
    while (!rx_empty && got < 40) begin
      tick(); rx_pop = 1'b1;
      tick(); rx_pop = 1'b0;
      chk($sformatf("R6 vec%0d rx byte %0d", i, got), 32'(rx_byte),
          32'((blk_mode && got == 0) ? blk_cnt : 8'(8'h80 + got)));
      got++;
    end
    chk($sformatf("R4 R6 vec%0d rx count", i), 32'(got), 32'(v.rxn));
    clear_evt();
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // reset state
    chk("R1 reset busy", 32'(busy), 0);
    chk("R1 reset status", 32'(status), 0);
    chk("R10 reset evt", 32'(evt_done), 0);
    chk("R14 reset req", 32'(eng_req), 0);
    chk("R12 reset rx empty", 32'(rx_empty), 1);
    chk("R13 reset fast", 32'(eng_fast), 0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R13 speed bit
    tick(); cfg_fast = 1'b1; tick();
    chk("R13 fast set", 32'(eng_fast), 1);
    cfg_fast = 1'b0; tick();
    chk("R13 fast clear", 32'(eng_fast), 0);

    // R9 bad protocol
    model_clear();
    launch(4'd12, '0);
    chk("R9 busy stays low", 32'(busy), 0);
    chk("R9 status", 32'(status), 4);
    chk("R9 evt", 32'(evt_done), 1);
    repeat (5) tick();
    chk("R9 no engine activity", 32'(n_start + n_write + n_stop), 0);

    // R10 write-1-to-clear
    repeat (3) tick();
    chk("R10 holds without clear", 32'(evt_done), 1);
    clear_evt();
    tick();
    chk("R10 cleared", 32'(evt_done), 0);

    // R12 transmit flush, then quick command finds no entry
    model_clear();
    push_entry(9'h0A0);
    pulse_flush_tx();
    launch(4'd0, '0);
    wait_idle();
    chk("R12 tx flush underrun", 32'(status), 3);
    chk("R12 tx flush no write", 32'(n_write), 0);
    clear_evt();

    // R12 receive flush
    pulse_flush_tx(); model_clear(); blk_mode = 0; nack_at = 15;
    push_entry(9'h0A0); push_entry(9'h010); push_entry(9'h0A1);
    launch(4'd6, 6'd2);
    wait_idle();
    chk("R12 rx filled", 32'(rx_empty), 0);
    tick(); rx_flush = 1'b1; tick(); rx_flush = 1'b0;
    chk("R12 rx flushed", 32'(rx_empty), 1);
    clear_evt();

    // R11 enable low ignores go
    model_clear();
    push_entry(9'h0A0);
    tick(); enable = 1'b0;
    launch(4'd0, '0);
    repeat (6) tick();
    chk("R11 disabled busy", 32'(busy), 0);
    chk("R11 disabled no start", 32'(n_start), 0);
    enable = 1'b1;

    // R11 soft reset aborts a running transaction and empties the FIFOs
    pulse_flush_tx(); model_clear();
    push_entry(9'h0A0); push_entry(9'h010); push_entry(9'h177); push_entry(9'h0A0);
    launch(4'd3, '0);
    repeat (4) tick();
    chk("R1 busy while running", 32'(busy), 1);
    soft_rst = 1'b1; tick(); soft_rst = 1'b0;
    chk("R11 soft busy", 32'(busy), 0);
    chk("R11 soft req", 32'(eng_req), 0);
    chk("R11 soft status", 32'(status), 0);
    repeat (4) tick();
    model_clear();
    launch(4'd0, '0);
    wait_idle();
    chk("R11 soft emptied tx", 32'(status), 3);
    chk("R11 soft emptied tx writes", 32'(n_write), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule